// File: doc/BRIEF.md
# Serial Line Receiver with Error-Tagged Receive Queue

This block is the receive half of an asynchronous serial port. It watches the incoming line on a clock-enable that pulses sixteen times per bit period. It recovers one character at a time in one of four frame formats, with one or two stop bits and an even or odd parity sense. Each finished character goes into a first-in first-out queue as a 10-bit word. The word carries the character and its parity and framing error flags, so a reader sees each error next to the character it belongs to.

Status outputs show whether a word is waiting, whether the queue is at least half full, whether a character was lost because the queue was full, and whether words have sat unread for a programmed number of character times while the line was quiet. A one-cycle flush strobe empties the queue. Reception happens only while both the run and receive-enable inputs are high.

The frame decoder is a state machine with five states: `S_IDLE`, `S_START`, `S_DATA`, `S_PAR` and `S_STOP`. Its transitions are:
- `S_IDLE` to `S_START` on a tick that sees the line low.
- `S_START` to `S_DATA` when the mid-bit sample is low.
- `S_START` back to `S_IDLE` when the mid-bit sample is high (a false start).
- `S_DATA` to `S_PAR` after the last data bit in the formats that carry parity.
- `S_DATA` to `S_STOP` after the last data bit in the other formats.
- `S_PAR` to `S_STOP` after the parity sample.
- `S_STOP` to `S_IDLE` after the last stop sample, which delivers the word.
- Any state to `S_IDLE` whenever reception is disabled.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset, `rx_avail`, `rx_half`, `rx_overrun` and `rx_timeout` are low, and `rd_word` reads 0.
- R2: The word layout is fixed. Bit 9 is the framing error, set when any stop-bit sample is low. Bit 8 is the parity error in the formats with parity, computed as even parity when `par_odd`=0 and as odd parity when `par_odd`=1. The character sits in the low bits.
- R3: The `fmt` input selects the frame format, and `two_stop` selects two stop bits instead of one. The codes are:
  - 0: 8 data bits, no parity; bit 8 reads 0.
  - 1: 7 data bits plus parity; bit 7 reads 0.
  - 2: 8 data bits plus parity.
  - 3: 9 data bits, no parity; bit 8 is the ninth data bit.
- R4: A line held low for a whole frame in format 0 yields the word 0x200, which is a break.
- R5: `rx_avail` is high while the queue holds at least one word, and `rx_half` is high while it holds at least DEPTH/2 words. `rd_word` shows the oldest word, or 0 when the queue is empty. A cycle with `rd_stb` high removes the oldest word.
- R6: A frame that completes while the queue holds DEPTH words is discarded and sets `rx_overrun`. A read that removes a word clears it.
- R7: Frames are received only while both `run_en` and `rx_en` are high. Otherwise the line is ignored.
- R8: `rx_timeout` rises once the queue has been non-empty and the decoder idle for `tmo_limit` character times of CHAR_TICKS ticks each. A read, a completed frame, a flush, an empty queue or a limit of 0 clears it and restarts the count.
- R9: `rx_flush` empties the queue and clears `rx_overrun` and `rx_timeout`.
- R10: The start bit is confirmed by a low sample at the 8th tick after the tick that first saw the line low. A high sample there abandons the frame. Every later bit is sampled 16 ticks after the previous sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Sampling enable, sixteen per bit period |
| rxd | input | 1 | Serial line, idle high |
| run_en | input | 1 | Port running |
| rx_en | input | 1 | Receiver enable |
| fmt | input | 2 | Frame format code |
| par_odd | input | 1 | 1 selects odd parity |
| two_stop | input | 1 | 1 selects two stop bits |
| rx_flush | input | 1 | Strobe that empties the queue |
| rd_stb | input | 1 | Read strobe, removes the oldest word |
| tmo_limit | input | 8 | Idle timeout in character times, 0 disables |
| rd_word | output | 10 | Oldest word: errors in bits 9:8, character below |
| rx_avail | output | 1 | At least one word waiting |
| rx_half | output | 1 | Queue at least half full |
| rx_overrun | output | 1 | Sticky lost-character flag |
| rx_timeout | output | 1 | Words waiting past the idle limit |

## Verification
Frames are sent in all four formats with good parity and with bad parity, so an error bit placed in the wrong position or inverted shows up in the read word. Stop bits are forced low on the first stop and on the second stop, to tell a single-stop check from a two-stop check. A full-length low line that then rises inside the stop bit tests break recovery and the false-start path together. Short glitches and frames sent while disabled must leave the queue untouched. A run of seventeen frames reaches the half and full boundaries and the overrun, and a quiet wait with one word queued drives the timeout count across its limit.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    typedef enum logic [1:0] {
        FMT_8N = 2'd0,
        FMT_7P = 2'd1,
        FMT_8P = 2'd2,
        FMT_9N = 2'd3
    } rx_fmt_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP
    } rx_state_e;

    localparam int WORD_W = 10;
endpackage

// File: rtl/rx_deframer.sv
module rx_deframer
    import uart_rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                rxd,
    input  logic                active,
    input  rx_fmt_e             fmt,
    input  logic                par_odd,
    input  logic                two_stop,
    output logic                done,
    output logic [WORD_W-1:0]   word,
    output logic                idle
);
    rx_state_e   state, nxt;
    logic [3:0]  cnt;
    logic [3:0]  bidx;
    logic [8:0]  sh;
    logic        pe_r, fe_r;
    logic [3:0]  nbits;
    logic        has_par, mid, start_mid, last_stop, fe_now;

    assign nbits     = (fmt == FMT_7P) ? 4'd7 : ((fmt == FMT_9N) ? 4'd9 : 4'd8);
    assign has_par   = (fmt == FMT_7P) || (fmt == FMT_8P);
    assign mid       = tick && (cnt == 4'd15);
    assign start_mid = tick && (cnt == 4'd7);
    assign last_stop = (bidx == {3'b000, two_stop});
    assign fe_now    = fe_r | ~rxd;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next state and outputs
    always_comb begin
        nxt  = state;
        done = 1'b0;
        unique case (state)
            S_IDLE:  if (tick && !rxd) nxt = S_START;
            S_START: if (start_mid) nxt = rxd ? S_IDLE : S_DATA;
            S_DATA:  if (mid && bidx == nbits - 4'd1) nxt = has_par ? S_PAR : S_STOP;
            S_PAR:   if (mid) nxt = S_STOP;
            S_STOP:  if (mid && last_stop) begin
                         nxt  = S_IDLE;
                         done = active;
                     end
            default: nxt = S_IDLE;
        endcase
        if (!active) nxt = S_IDLE;
        idle = (state == S_IDLE);
        unique case (fmt)
            FMT_7P:  word = {fe_now, pe_r, 1'b0, sh[6:0]};
            FMT_8P:  word = {fe_now, pe_r, sh[7:0]};
            FMT_9N:  word = {fe_now, sh};
            default: word = {fe_now, 1'b0, sh[7:0]};
        endcase
    end

    // bit timing and shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0; bidx <= '0; sh <= '0; pe_r <= 1'b0; fe_r <= 1'b0;
        end else if (!active || state == S_IDLE) begin
            cnt <= '0; bidx <= '0; sh <= '0; pe_r <= 1'b0; fe_r <= 1'b0;
        end else if (tick) begin
            unique case (state)
                S_START: cnt <= (cnt == 4'd7) ? 4'd0 : cnt + 4'd1;
                S_DATA: begin
                    cnt <= cnt + 4'd1;
                    if (cnt == 4'd15) begin
                        sh[bidx] <= rxd;
                        bidx     <= (bidx == nbits - 4'd1) ? 4'd0 : bidx + 4'd1;
                    end
                end
                S_PAR: begin
                    cnt <= cnt + 4'd1;
                    if (cnt == 4'd15) pe_r <= rxd ^ (^sh) ^ par_odd;
                end
                S_STOP: begin
                    cnt <= cnt + 4'd1;
                    if (cnt == 4'd15) begin
                        fe_r <= fe_now;
                        bidx <= bidx + 4'd1;
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      push,
    input  logic [W-1:0]              din,
    input  logic                      pop,
    output logic [W-1:0]              head,
    output logic [$clog2(DEPTH):0]    count,
    output logic                      full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          wr_go, rd_go;

    assign full  = (count == (AW+1)'(DEPTH));
    assign wr_go = push && !full && !clr;
    assign rd_go = pop && (count != '0) && !clr;
    assign head  = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0; rd_ptr <= '0; count <= '0;
        end else if (clr) begin
            wr_ptr <= '0; rd_ptr <= '0; count <= '0;
        end else begin
            if (wr_go) wr_ptr <= wr_ptr + 1'b1;
            if (rd_go) rd_ptr <= rd_ptr + 1'b1;
            count <= count + (AW+1)'(wr_go) - (AW+1)'(rd_go);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_go) mem[wr_ptr] <= din;
    end
endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
    parameter int CHAR_TICKS = 160
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       restart,
    input  logic       armed,
    input  logic       line_idle,
    input  logic [7:0] limit,
    output logic       flag
);
    localparam int TW = $clog2(CHAR_TICKS);

    logic [TW-1:0] tcnt;
    logic [7:0]    ccnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt <= '0; ccnt <= '0; flag <= 1'b0;
        end else if (restart || !armed || limit == 8'd0) begin
            tcnt <= '0; ccnt <= '0; flag <= 1'b0;
        end else if (line_idle && tick && !flag) begin
            if (tcnt == TW'(CHAR_TICKS - 1)) begin
                tcnt <= '0;
                ccnt <= ccnt + 8'd1;
                if (ccnt + 8'd1 == limit) flag <= 1'b1;
            end else begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int CHAR_TICKS = 160
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              rxd,
    input  logic              run_en,
    input  logic              rx_en,
    input  logic [1:0]        fmt,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic              rx_flush,
    input  logic              rd_stb,
    input  logic [7:0]        tmo_limit,
    output logic [WORD_W-1:0] rd_word,
    output logic              rx_avail,
    output logic              rx_half,
    output logic              rx_overrun,
    output logic              rx_timeout
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic              rx_active, frame_done, line_idle, q_full, pop_fire;
    logic [WORD_W-1:0] frame_word, q_head;
    logic [CW-1:0]     q_count;

    assign rx_active = run_en & rx_en;

    rx_deframer u_deframer (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .rxd(rxd),
        .active(rx_active), .fmt(rx_fmt_e'(fmt)), .par_odd(par_odd),
        .two_stop(two_stop), .done(frame_done), .word(frame_word),
        .idle(line_idle)
    );

    rx_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(rx_flush), .push(frame_done),
        .din(frame_word), .pop(rd_stb), .head(q_head), .count(q_count),
        .full(q_full)
    );

    assign rx_avail = (q_count != '0);
    assign rx_half  = (q_count >= CW'(DEPTH / 2));
    assign rd_word  = rx_avail ? q_head : '0;
    assign pop_fire = rd_stb & rx_avail;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    rx_overrun <= 1'b0;
        else if (rx_flush)             rx_overrun <= 1'b0;
        else if (frame_done && q_full) rx_overrun <= 1'b1;
        else if (pop_fire)             rx_overrun <= 1'b0;
    end

    rx_idle_timer #(.CHAR_TICKS(CHAR_TICKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick16),
        .restart(rx_flush | pop_fire | frame_done), .armed(rx_avail),
        .line_idle(line_idle), .limit(tmo_limit), .flag(rx_timeout)
    );
endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       flush,
    input logic       rd_stb,
    input logic       avail,
    input logic       half,
    input logic       overrun,
    input logic       timeout,
    input logic       done,
    input logic       active,
    input logic [7:0] limit
);
    // R9
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!avail && !overrun && !timeout));

    // R6
    overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> ($past(done) && $past(half)));

    // R6
    overrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && avail && !done) |=> !overrun);

    // R8
    timeout_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> ($past(avail) && $past(limit) != 8'd0));

    // R7
    gated_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !done);

    // R5
    avail_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(avail) |-> $past(done));
endmodule

bind uart_rx_fifo uart_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush), .rd_stb(rd_stb),
    .avail(rx_avail), .half(rx_half), .overrun(rx_overrun),
    .timeout(rx_timeout), .done(frame_done), .active(rx_active),
    .limit(tmo_limit)
);

// File: tb/tb_uart_rx_fifo.sv
module tb_uart_rx_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;
    localparam int CT    = 160;

    logic       clk = 0, rst_n = 0, tick16 = 0, rxd = 1;
    logic       run_en = 1, rx_en = 1, par_odd = 0, two_stop = 0;
    logic       rx_flush = 0, rd_stb = 0;
    logic [1:0] fmt = 2'd0;
    logic [7:0] tmo_limit = 8'd0;
    logic [9:0] rd_word;
    logic       rx_avail, rx_half, rx_overrun, rx_timeout;

    int total = 0, bad = 0;
    bit chk_on = 0;

    uart_rx_fifo dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .run_en(run_en), .rx_en(rx_en), .fmt(fmt), .par_odd(par_odd),
        .two_stop(two_stop), .rx_flush(rx_flush), .rd_stb(rd_stb),
        .tmo_limit(tmo_limit), .rd_word(rd_word), .rx_avail(rx_avail),
        .rx_half(rx_half), .rx_overrun(rx_overrun), .rx_timeout(rx_timeout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) tick16 <= ~tick16;

    function automatic bit par_of(int d);
        return ^(d[8:0]);
    endfunction

    function automatic int mk_word(int fm, int d, bit pe, bit fe);
        int w;
        case (fm)
            1:       w = (int'(pe) << 8) | (d & 'h7F);
            2:       w = (int'(pe) << 8) | (d & 'hFF);
            3:       w = d & 'h1FF;
            default: w = d & 'hFF;
        endcase
        return w | (int'(fe) << 9);
    endfunction

    // behavioural reference model
    int q[$];
    bit m_busy, m_pe, m_fe, m_ovr, m_tmo;
    int m_t, m_data, m_tc, m_cc;

    always @(posedge clk) begin
        int nb, hp, ns, k, s, w;
        bit done, pop, full, act, idle_pre, armed;
        if (!rst_n) begin
            q.delete(); m_busy = 0; m_ovr = 0; m_tmo = 0; m_tc = 0; m_cc = 0;
            m_t = 0; m_data = 0; m_pe = 0; m_fe = 0;
        end else begin
            nb = (fmt == 2'd1) ? 7 : ((fmt == 2'd3) ? 9 : 8);
            hp = (fmt == 2'd1 || fmt == 2'd2) ? 1 : 0;
            ns = two_stop ? 2 : 1;
            act = run_en && rx_en;
            idle_pre = !m_busy;
            armed = q.size() > 0;
            done = 0; w = 0;
            if (!act) m_busy = 0;
            else if (!m_busy) begin
                if (tick16 && !rxd) begin
                    m_busy = 1; m_t = 0; m_data = 0; m_pe = 0; m_fe = 0;
                end
            end else if (tick16) begin
                m_t++;
                if (m_t % 16 == 8) begin
                    k = (m_t - 8) / 16;
                    if (k == 0) begin
                        if (rxd) m_busy = 0;
                    end else if (k <= nb) begin
                        m_data = m_data | (int'(rxd) << (k - 1));
                    end else if (hp == 1 && k == nb + 1) begin
                        m_pe = rxd ^ par_of(m_data) ^ par_odd;
                    end else begin
                        s = k - nb - hp;
                        if (!rxd) m_fe = 1;
                        if (s == ns) begin
                            done = 1; m_busy = 0;
                            w = mk_word(int'(fmt), m_data, m_pe, m_fe);
                        end
                    end
                end
            end
            pop  = rd_stb && q.size() > 0;
            full = q.size() == DEPTH;
            if (rx_flush) begin
                q.delete(); m_ovr = 0;
            end else begin
                if (done && full) m_ovr = 1;
                else if (pop) m_ovr = 0;
                if (pop) void'(q.pop_front());
                if (done && !full) q.push_back(w);
            end
            if (rx_flush || pop || done || !armed || tmo_limit == 0) begin
                m_tc = 0; m_cc = 0; m_tmo = 0;
            end else if (idle_pre && tick16 && !m_tmo) begin
                if (m_tc == CT - 1) begin
                    m_tc = 0; m_cc++;
                    if (m_cc == int'(tmo_limit)) m_tmo = 1;
                end else m_tc++;
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (chk_on) begin
            check("R2 word", int'(rd_word), q.size() > 0 ? q[0] : 0);
            check("R5 avail", int'(rx_avail), int'(q.size() > 0));
            check("R5 half", int'(rx_half), int'(q.size() >= DEPTH/2));
            check("R6 overrun", int'(rx_overrun), int'(m_ovr));
            check("R8 timeout", int'(rx_timeout), int'(m_tmo));
        end
    end

    task automatic bit_out(input bit b, input int ticks);
        rxd = b;
        repeat (2 * ticks) @(negedge clk);
    endtask

    task automatic send(input int d, input bit bad_par, input bit bad_stop);
        int nb;
        bit hp;
        nb = (fmt == 2'd1) ? 7 : ((fmt == 2'd3) ? 9 : 8);
        hp = (fmt == 2'd1 || fmt == 2'd2);
        bit_out(0, 16);
        for (int i = 0; i < nb; i++) bit_out(d[i], 16);
        if (hp) bit_out(par_of(d & ((1 << nb) - 1)) ^ par_odd ^ bad_par, 16);
        if (two_stop) bit_out(1, 16);
        bit_out(!bad_stop, 16);
        bit_out(1, 16);
    endtask

    task automatic read_one();
        rd_stb = 1; @(negedge clk); rd_stb = 0; @(negedge clk);
    endtask

    task automatic flush();
        rx_flush = 1; @(negedge clk); rx_flush = 0; @(negedge clk);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk_on = 1;
        // R1 reset state
        check("R1 avail", int'(rx_avail), 0);
        check("R1 word", int'(rd_word), 0);
        check("R1 flags", int'({rx_half, rx_overrun, rx_timeout}), 0);

        // R3 format 0
        fmt = 2'd0; send('hA5, 0, 0);
        check("R3 fmt0", int'(rd_word), 'h0A5); read_one();
        // R2 parity even good / bad
        fmt = 2'd2; send('h3C, 0, 0);
        check("R2 even ok", int'(rd_word), 'h03C); read_one();
        send('h3C, 1, 0);
        check("R2 even bad", int'(rd_word), 'h13C); read_one();
        par_odd = 1; send('h81, 0, 0);
        check("R2 odd ok", int'(rd_word), 'h081); read_one();
        send('h81, 1, 0);
        check("R2 odd bad", int'(rd_word), 'h181); read_one();
        par_odd = 0;
        // R3 format 1 and 3
        fmt = 2'd1; send('h55, 0, 0);
        check("R3 fmt1", int'(rd_word), 'h055); read_one();
        fmt = 2'd3; send('h1A5, 0, 0);
        check("R3 fmt3", int'(rd_word), 'h1A5); read_one();
        // R2 framing error, single and second stop
        fmt = 2'd0; send('h81, 0, 1);
        check("R2 frame err", int'(rd_word), 'h281); read_one();
        two_stop = 1; send('h42, 0, 1);
        check("R3 two stop fe", int'(rd_word), 'h242); read_one();
        send('h42, 0, 0);
        check("R3 two stop ok", int'(rd_word), 'h042); read_one();
        two_stop = 0;
        // R4 break, then R10 false start on the tail
        bit_out(0, 156); bit_out(1, 48);
        check("R4 break", int'(rd_word), 'h200);
        check("R10 false start", int'(rx_half), 0);
        read_one();
        // R10 short glitch ignored
        bit_out(0, 4); bit_out(1, 200);
        check("R10 glitch", int'(rx_avail), 0);
        // R7 disabled receive
        rx_en = 0; send('h11, 0, 0);
        check("R7 rx_en low", int'(rx_avail), 0);
        rx_en = 1; run_en = 0; send('h22, 0, 0);
        check("R7 run low", int'(rx_avail), 0);
        run_en = 1;
        // R5 / R6 fill, half, overrun
        for (int i = 0; i < DEPTH; i++) begin
            send(i + 'h30, 0, 0);
            if (i == DEPTH/2 - 2) check("R5 below half", int'(rx_half), 0);
            if (i == DEPTH/2 - 1) check("R5 at half", int'(rx_half), 1);
        end
        check("R6 no overrun yet", int'(rx_overrun), 0);
        send('h77, 0, 0);
        check("R6 overrun set", int'(rx_overrun), 1);
        check("R6 oldest kept", int'(rd_word), 'h030);
        read_one();
        check("R6 overrun cleared", int'(rx_overrun), 0);
        for (int i = 1; i < DEPTH; i++) begin
            check("R5 order", int'(rd_word), i + 'h30);
            read_one();
        end
        check("R5 drained", int'(rx_avail), 0);
        // R8 timeout
        tmo_limit = 8'd2;
        send('h5A, 0, 0);
        repeat (300) @(negedge clk);
        check("R8 early", int'(rx_timeout), 0);
        repeat (700) @(negedge clk);
        check("R8 fired", int'(rx_timeout), 1);
        read_one();
        check("R8 read clears", int'(rx_timeout), 0);
        // R9 flush
        send('h01, 0, 0); send('h02, 0, 0);
        repeat (1000) @(negedge clk);
        flush();
        check("R9 empty", int'(rx_avail), 0);
        check("R9 flags", int'({rx_overrun, rx_timeout}), 0);
        tmo_limit = 8'd0;
        repeat (20) @(negedge clk);
        finish_run();
    end
endmodule